// File: doc/BRIEF.md
# Stage-One Translation Control Register with Access Routing

This block holds the 64-bit control word that configures stage-one address translation for the two lower privilege levels. It is reached through a system-register access port. Each request carries an instruction encoding split into five fields (op0, op1, CRn, CRm, op2), a read/write flag, the current privilege level (0 to 3) and a set of hypervisor control inputs. The block matches the encoding and then picks one of five outcomes. It can perform the access. It can return an undefined-instruction response. It can trap to level 2 with a syndrome class. It can redirect the access to a memory slot used for nested virtualisation. Or it can redirect the access to the level-2 control register while the hypervisor runs in host mode.

Alongside the stored value, the block gives the translation logic effective values that depend on other fields and not only on the bits written. The dirty-state enable is suppressed when hardware access-flag update is off. Each region's hardware-use bits are suppressed when that region's hierarchical-permission-disable bit is clear. The output-address size field is decoded to a bit count and clamped to the supported physical address width.

Top module: `xlat_ctl_reg`

## Requirements
- R1: After reset the stored value `cfg_value` is all zeros and `rsp_valid` is 0.
- R2: A request whose encoding matches the primary form (op0=3, op1=0, CRn=2, CRm=0, op2=2) or the alias form (the same fields but op1=5) gives exactly one response, with `rsp_valid` high in the cycle after `req_valid`. A request that matches neither form gives no response and changes nothing.
- R3: Any request from level 0, through either encoding, responds with kind UNDEF (code 1) and leaves the stored value unchanged.
- R4: At level 1 with `hv_enabled`=1, a write while `hv_trap_wr`=1 or a read while `hv_trap_rd`=1 responds with kind TRAP (code 2) and syndrome 0x18, and leaves the stored value unchanged. `rsp_syndrome` is 0 for every other kind.
- R5: At level 1, when no trap applies and `hv_nested`=3'b111, the response is kind MEM (code 3) with `rsp_mem_off`=0x120, and the stored value is unchanged. `rsp_mem_off` is 0 for every other kind.
- R6: Through the primary encoding, level 2 with `hv_host_mode`=1 responds with kind HOST (code 4) and leaves the stored value unchanged. Level 2 without host mode, and level 3, respond with kind OK (code 0) and perform the access.
- R7: The alias encoding performs the access (kind OK) only at level 2 or 3 with `hv_host_mode`=1. In every other case it responds with kind UNDEF.
- R8: A performed write stores the write data, with bits 63:62, 35 and 6 forced to 0, at the clock edge that raises `rsp_valid`. A performed read returns the stored value on `rsp_rdata`. `rsp_rdata` is 0 for writes and for every kind other than OK.
- R9: `eff_af_en` equals stored bit 39. `eff_dirty_en` equals stored bit 40 AND stored bit 39. A read still returns bit 40 as it was stored.
- R10: `eff_hwu0` equals stored bits 46:43 when stored bit 41 is 1, and 0 otherwise. `eff_hwu1` equals stored bits 50:47 when stored bit 42 is 1, and 0 otherwise.
- R11: `eff_oa_bits` decodes stored bits 34:32 as follows: 0→32, 1→36, 2→40, 3→42, 4→44, 5→48, 6→52 and 7→52. The result is then clamped to `PA_BITS`, which defaults to 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| hv_enabled | input | 1 | Hypervisor level enabled |
| hv_host_mode | input | 1 | Hypervisor running in host mode |
| hv_trap_wr | input | 1 | Trap level-1 writes to level 2 |
| hv_trap_rd | input | 1 | Trap level-1 reads to level 2 |
| hv_nested | input | 3 | Nested-virtualisation control triple |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | 0 OK, 1 UNDEF, 2 TRAP, 3 MEM, 4 HOST |
| rsp_rdata | output | 64 | Read data for a performed read |
| rsp_syndrome | output | 6 | Syndrome class of a trap |
| rsp_mem_off | output | 12 | Memory-slot offset of a MEM redirect |
| cfg_value | output | 64 | Stored control word |
| eff_af_en | output | 1 | Effective access-flag update enable |
| eff_dirty_en | output | 1 | Effective dirty-state management enable |
| eff_hwu0 | output | 4 | Effective hardware-use bits, lower region |
| eff_hwu1 | output | 4 | Effective hardware-use bits, upper region |
| eff_oa_bits | output | 6 | Effective output-address size in bits |

## Verification
The routing is tried over every privilege level, with each hypervisor input raised on its own and then together. This separates trap priority over the memory redirect, read traps from write traps, and host redirect from a performed access. Both encodings are also tried, along with near-miss encodings, so alias gating and the no-response case can be told apart from undefined responses. The effective fields are driven with each enable held low and then high under fixed payload bits, so suppression can be told apart from a wrong bit position. All eight size codes are written, which exposes the decode table and the clamp separately. Reads after every rejected access show that the stored word did not move.

// File: rtl/xlat_ctl_pkg.sv
// Shared types and constants for the translation control register.
// Assumes a 64-bit control word. Field positions are fixed because software
// writes them directly.
package xlat_ctl_pkg;

    typedef enum logic [2:0] {
        ACC_OK    = 3'd0,
        ACC_UNDEF = 3'd1,
        ACC_TRAP  = 3'd2,
        ACC_MEM   = 3'd3,
        ACC_HOST  = 3'd4
    } acc_kind_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam int          WORD_W     = 64;
    localparam int          HWU_W      = 4;
    localparam int          OA_W       = 6;
    localparam logic [WORD_W-1:0] RSVD_MASK = 64'hC000_0008_0000_0040;
    localparam logic [5:0]  TRAP_CLASS = 6'h18;
    localparam logic [11:0] NV_SLOT    = 12'h120;

    localparam logic [2:0]  OP1_MAIN   = 3'b000;
    localparam logic [2:0]  OP1_ALIAS  = 3'b101;

    // Field positions.
    localparam int POS_IPS   = 32;
    localparam int POS_HA    = 39;
    localparam int POS_HD    = 40;
    localparam int POS_HPD0  = 41;
    localparam int POS_HPD1  = 42;
    localparam int POS_HWU0  = 43;
    localparam int POS_HWU1  = 47;

endpackage

// File: rtl/xlat_access_decode.sv
// Access decoder: matches the encoding and selects the outcome of a request
// from its privilege level and the hypervisor controls. Purely combinational.
// Assumes the request fields are stable while req_valid is high.
module xlat_access_decode
    import xlat_ctl_pkg::*;
(
    input  sysenc_t    enc,
    input  logic       is_write,
    input  logic [1:0] el,
    input  logic       hv_enabled,
    input  logic       hv_host_mode,
    input  logic       hv_trap_wr,
    input  logic       hv_trap_rd,
    input  logic [2:0] hv_nested,
    output logic       hit,
    output acc_kind_e  kind
);

    logic common_ok;
    logic is_main;
    logic is_alias;

    // Match the fields shared by both forms, then the op1 variant.
    always_comb begin
        common_ok = (enc.op0 == 2'b11) && (enc.crn == 4'b0010) &&
                    (enc.crm == 4'b0000) && (enc.op2 == 3'b010);
        is_main   = common_ok && (enc.op1 == OP1_MAIN);
        is_alias  = common_ok && (enc.op1 == OP1_ALIAS);
        hit       = is_main || is_alias;
    end

    // Route by privilege level; at level 1 the traps take priority over the redirect.
    always_comb begin
        kind = ACC_UNDEF;
        if (el == 2'd0) begin
            kind = ACC_UNDEF;
        end else if (is_alias) begin
            kind = (el[1] && hv_host_mode) ? ACC_OK : ACC_UNDEF;
        end else begin
            unique case (el)
                2'd1: begin
                    if (hv_enabled && is_write && hv_trap_wr)
                        kind = ACC_TRAP;
                    else if (hv_enabled && !is_write && hv_trap_rd)
                        kind = ACC_TRAP;
                    else if (hv_nested == 3'b111)
                        kind = ACC_MEM;
                    else
                        kind = ACC_OK;
                end
                2'd2:    kind = hv_host_mode ? ACC_HOST : ACC_OK;
                default: kind = ACC_OK;
            endcase
        end
    end

endmodule

// File: rtl/xlat_eff_fields.sv
// Effective-value derivation: turns the stored word into the values the
// translation logic uses. Assumes PA_BITS lies between 32 and 63.
module xlat_eff_fields
    import xlat_ctl_pkg::*;
#(
    parameter int PA_BITS = 48
) (
    input  logic [WORD_W-1:0] cfg,
    output logic              af_en,
    output logic              dirty_en,
    output logic [HWU_W-1:0]  hwu0,
    output logic [HWU_W-1:0]  hwu1,
    output logic [OA_W-1:0]   oa_bits
);

    localparam int          REGIONS = 2;
    localparam logic [OA_W-1:0] PA_LIM = OA_W'(PA_BITS);

    logic [OA_W-1:0] oa_dec;
    logic [HWU_W-1:0] hwu_eff [REGIONS];

    // Dirty-state management needs access-flag update to be on.
    always_comb begin
        af_en    = cfg[POS_HA];
        dirty_en = cfg[POS_HD] & cfg[POS_HA];
    end

    // One gate per region: hardware-use bits pass only with that region's disable bit set.
    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        localparam int HWU_POS = (r == 0) ? POS_HWU0 : POS_HWU1;
        localparam int HPD_POS = (r == 0) ? POS_HPD0 : POS_HPD1;
        always_comb hwu_eff[r] = cfg[HWU_POS +: HWU_W] & {HWU_W{cfg[HPD_POS]}};
    end

    assign hwu0 = hwu_eff[0];
    assign hwu1 = hwu_eff[1];

    // Size code to bit count; the top code is held at the next-lower size.
    always_comb begin
        unique case (cfg[POS_IPS +: 3])
            3'd0:    oa_dec = 6'd32;
            3'd1:    oa_dec = 6'd36;
            3'd2:    oa_dec = 6'd40;
            3'd3:    oa_dec = 6'd42;
            3'd4:    oa_dec = 6'd44;
            3'd5:    oa_dec = 6'd48;
            default: oa_dec = 6'd52;
        endcase
        oa_bits = (oa_dec > PA_LIM) ? PA_LIM : oa_dec;
    end

endmodule

// File: rtl/xlat_ctl_reg.sv
// Translation control register top: storage, access routing and a registered
// response one cycle after each matching request. Assumes at most one request
// per cycle and synchronous active-low reset.
module xlat_ctl_reg
    import xlat_ctl_pkg::*;
#(
    parameter int PA_BITS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [1:0]  req_el,
    input  logic [63:0] req_wdata,
    input  logic        hv_enabled,
    input  logic        hv_host_mode,
    input  logic        hv_trap_wr,
    input  logic        hv_trap_rd,
    input  logic [2:0]  hv_nested,
    output logic        rsp_valid,
    output logic [2:0]  rsp_kind,
    output logic [63:0] rsp_rdata,
    output logic [5:0]  rsp_syndrome,
    output logic [11:0] rsp_mem_off,
    output logic [63:0] cfg_value,
    output logic        eff_af_en,
    output logic        eff_dirty_en,
    output logic [3:0]  eff_hwu0,
    output logic [3:0]  eff_hwu1,
    output logic [5:0]  eff_oa_bits
);

    sysenc_t           enc;
    logic              dec_hit;
    acc_kind_e         dec_kind;
    logic              take;
    logic [WORD_W-1:0] store_q;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

    xlat_access_decode u_decode (
        .enc          (enc),
        .is_write     (req_write),
        .el           (req_el),
        .hv_enabled   (hv_enabled),
        .hv_host_mode (hv_host_mode),
        .hv_trap_wr   (hv_trap_wr),
        .hv_trap_rd   (hv_trap_rd),
        .hv_nested    (hv_nested),
        .hit          (dec_hit),
        .kind         (dec_kind)
    );

    assign take = req_valid && dec_hit;

    // Control word storage; only a performed write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (take && req_write && dec_kind == ACC_OK)
            store_q <= req_wdata & ~RSVD_MASK;
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_kind     <= ACC_OK;
            rsp_rdata    <= '0;
            rsp_syndrome <= '0;
            rsp_mem_off  <= '0;
        end else begin
            rsp_valid    <= take;
            rsp_kind     <= take ? dec_kind : ACC_OK;
            rsp_rdata    <= (take && !req_write && dec_kind == ACC_OK) ? store_q : '0;
            rsp_syndrome <= (take && dec_kind == ACC_TRAP) ? TRAP_CLASS : '0;
            rsp_mem_off  <= (take && dec_kind == ACC_MEM) ? NV_SLOT : '0;
        end
    end

    assign cfg_value = store_q;

    xlat_eff_fields #(.PA_BITS(PA_BITS)) u_eff (
        .cfg      (store_q),
        .af_en    (eff_af_en),
        .dirty_en (eff_dirty_en),
        .hwu0     (eff_hwu0),
        .hwu1     (eff_hwu1),
        .oa_bits  (eff_oa_bits)
    );

endmodule

// File: rtl/xlat_ctl_chk.sv
// Property checker for xlat_ctl_reg, attached by bind. Observes ports only.
module xlat_ctl_chk #(
    parameter int PA_BITS = 48
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  req_el,
    input logic        rsp_valid,
    input logic [2:0]  rsp_kind,
    input logic [5:0]  rsp_syndrome,
    input logic [63:0] cfg_value,
    input logic        eff_af_en,
    input logic        eff_dirty_en,
    input logic [5:0]  eff_oa_bits
);

    logic enc_hit;
    assign enc_hit = (req_op0 == 2'b11) && (req_crn == 4'b0010) && (req_crm == 4'b0000) &&
                     (req_op2 == 3'b010) && (req_op1 == 3'b000 || req_op1 == 3'b101);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && enc_hit |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && enc_hit) |=> !rsp_valid);

    // R3
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && enc_hit && req_el == 2'd0 |=> rsp_kind == 3'd1);

    // R4
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 3'd2 |-> rsp_syndrome == 6'h18);

    // R4
    reject_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind != 3'd0 |-> cfg_value == $past(cfg_value));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_value[63:62] == 2'b00 && !cfg_value[35] && !cfg_value[6]);

    // R9
    dirty_needs_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_dirty_en |-> eff_af_en && cfg_value[40]);

    // R11
    oa_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(eff_oa_bits) <= PA_BITS);

endmodule

bind xlat_ctl_reg xlat_ctl_chk #(.PA_BITS(PA_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op0      (req_op0),
    .req_op1      (req_op1),
    .req_crn      (req_crn),
    .req_crm      (req_crm),
    .req_op2      (req_op2),
    .req_el       (req_el),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (rsp_kind),
    .rsp_syndrome (rsp_syndrome),
    .cfg_value    (cfg_value),
    .eff_af_en    (eff_af_en),
    .eff_dirty_en (eff_dirty_en),
    .eff_oa_bits  (eff_oa_bits)
);

// File: tb/test_xlat_ctl_reg.sv
// Bench: a behavioural reference model updated at each rising edge and
// compared with every output at each falling edge.
module test_xlat_ctl_reg;

    localparam int PA = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b000;
    logic [3:0]  req_crn = 4'b0010, req_crm = 4'b0000;
    logic [2:0]  req_op2 = 3'b010;
    logic [1:0]  req_el = 2'd1;
    logic [63:0] req_wdata = '0;
    logic        hv_enabled = 1'b0, hv_host_mode = 1'b0, hv_trap_wr = 1'b0, hv_trap_rd = 1'b0;
    logic [2:0]  hv_nested = 3'b000;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [63:0] rsp_rdata, cfg_value;
    logic [5:0]  rsp_syndrome, eff_oa_bits;
    logic [11:0] rsp_mem_off;
    logic        eff_af_en, eff_dirty_en;
    logic [3:0]  eff_hwu0, eff_hwu1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    xlat_ctl_reg #(.PA_BITS(PA)) i_xlat_ctl_reg (.*);

    // Reference model state.
    logic [63:0] m_reg;
    bit          m_valid;
    int          m_kind;
    logic [63:0] m_rdata;
    bit          cmp_on = 0;
    string       m_tag = "R1";

    function automatic bit enc_main();
        return req_op0 == 2'b11 && req_op1 == 3'b000 && req_crn == 4'd2 && req_crm == 4'd0 && req_op2 == 3'd2;
    endfunction
    function automatic bit enc_alias();
        return req_op0 == 2'b11 && req_op1 == 3'b101 && req_crn == 4'd2 && req_crm == 4'd0 && req_op2 == 3'd2;
    endfunction

    function automatic int oa_of(logic [2:0] code);
        int sizes[8] = '{32, 36, 40, 42, 44, 48, 52, 52};
        return (sizes[code] > PA) ? PA : sizes[code];
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        cmp_on <= 1;
        if (!rst_n) begin
            m_reg = '0; m_valid = 0; m_kind = 0; m_rdata = '0; m_tag = "R1";
        end else if (req_valid && (enc_main() || enc_alias())) begin
            m_valid = 1;
            if (req_el == 0) begin m_kind = 1; m_tag = "R3"; end
            else if (enc_alias()) begin
                m_kind = (req_el >= 2 && hv_host_mode) ? 0 : 1; m_tag = "R7";
            end else if (req_el == 1) begin
                if (hv_enabled && ((req_write && hv_trap_wr) || (!req_write && hv_trap_rd))) begin
                    m_kind = 2; m_tag = "R4";
                end else if (hv_nested == 3'b111) begin m_kind = 3; m_tag = "R5"; end
                else begin m_kind = 0; m_tag = "R8"; end
            end else if (req_el == 2 && hv_host_mode) begin m_kind = 4; m_tag = "R6"; end
            else begin m_kind = 0; m_tag = "R6"; end
            m_rdata = (m_kind == 0 && !req_write) ? m_reg : '0;
            if (m_kind == 0 && req_write) begin
                m_reg = req_wdata;
                m_reg[63:62] = 2'b00; m_reg[35] = 1'b0; m_reg[6] = 1'b0;
            end
        end else begin
            m_valid = 0; m_kind = 0; m_rdata = '0; m_tag = "R2";
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Comparison at each falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(m_tag, "rsp_valid", 64'(rsp_valid), 64'(m_valid));
            if (m_valid) begin
                chk(m_tag, "rsp_kind", 64'(rsp_kind), 64'(m_kind));
                chk("R8", "rsp_rdata", rsp_rdata, m_rdata);
                chk("R4", "rsp_syndrome", 64'(rsp_syndrome), (m_kind == 2) ? 64'h18 : 64'h0);
                chk("R5", "rsp_mem_off", 64'(rsp_mem_off), (m_kind == 3) ? 64'h120 : 64'h0);
            end
            chk("R8", "cfg_value", cfg_value, m_reg);
            chk("R9", "eff_af_en", 64'(eff_af_en), 64'(m_reg[39]));
            chk("R9", "eff_dirty_en", 64'(eff_dirty_en), 64'(m_reg[40] && m_reg[39]));
            chk("R10", "eff_hwu0", 64'(eff_hwu0), m_reg[41] ? 64'(m_reg[46:43]) : 64'h0);
            chk("R10", "eff_hwu1", 64'(eff_hwu1), m_reg[42] ? 64'(m_reg[50:47]) : 64'h0);
            chk("R11", "eff_oa_bits", 64'(eff_oa_bits), 64'(oa_of(m_reg[34:32])));
        end
    end

    // One request cycle, driven on the falling edge.
    task automatic access(bit wr, logic [1:0] el, logic [2:0] op1, logic [63:0] data);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_el = el; req_op1 = op1; req_wdata = data;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset cfg", cfg_value, 64'h0);
        chk("R1", "reset valid", 64'(rsp_valid), 64'h0);
        rst_n = 1;
        // R8: all-ones write, reserved bits forced to zero, then read
        access(1, 1, 3'b000, 64'hFFFF_FFFF_FFFF_FFFF);
        access(0, 1, 3'b000, '0);
        // R9 / R10: enables low, then high, under fixed payload
        access(1, 1, 3'b000, 64'h0007_F980_0000_0000);
        access(1, 1, 3'b000, 64'h0007_FE80_0000_0000);
        access(1, 1, 3'b000, 64'h0007_F800_8000_0000);
        // R11: every size code
        for (int c = 0; c < 8; c++) access(1, 1, 3'b000, 64'(c) << 32);
        access(1, 1, 3'b000, 64'h0000_0123_4567_89AB);
        // R3: level 0 via both encodings
        access(1, 0, 3'b000, 64'h0);
        access(0, 0, 3'b101, 64'h0);
        access(0, 1, 3'b000, '0);
        // R4: traps at level 1
        hv_enabled = 1; hv_trap_wr = 1;
        access(1, 1, 3'b000, 64'h5);
        access(0, 1, 3'b000, '0);
        hv_trap_wr = 0; hv_trap_rd = 1;
        access(0, 1, 3'b000, '0);
        access(1, 1, 3'b000, 64'h0000_0001_0000_0010);
        hv_nested = 3'b111; hv_trap_rd = 1;
        access(0, 1, 3'b000, '0);
        // R5: memory redirect, with and without hypervisor enabled
        hv_trap_rd = 0;
        access(1, 1, 3'b000, 64'hAA);
        hv_enabled = 0; hv_trap_wr = 1;
        access(0, 1, 3'b000, '0);
        hv_nested = 3'b011; hv_trap_wr = 0;
        access(0, 1, 3'b000, '0);
        // R6: level 2 host and non-host, level 3
        hv_enabled = 1; hv_host_mode = 1;
        access(1, 2, 3'b000, 64'h77);
        access(0, 3, 3'b000, '0);
        hv_host_mode = 0;
        access(1, 2, 3'b000, 64'h0000_0002_0000_1234);
        access(1, 3, 3'b000, 64'h0000_0003_0000_4321);
        // R7: alias gating
        access(1, 1, 3'b101, 64'h99);
        access(1, 2, 3'b101, 64'h98);
        hv_host_mode = 1;
        access(1, 2, 3'b101, 64'h0000_0004_0000_0055);
        access(0, 3, 3'b101, '0);
        // R2: near-miss encodings give no response; back-to-back requests
        access(1, 3, 3'b001, 64'hDEAD);
        req_crm = 4'd1; access(1, 3, 3'b000, 64'hBEEF); req_crm = 4'd0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_el = 3; req_op1 = 3'b000;
        @(negedge clk); req_el = 0;
        @(negedge clk); req_valid = 0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule